// File: doc/BRIEF.md
# Receive Header-Split Buffer Placement Engine

This block decides where the bytes of one received frame are placed for one receive descriptor. Each request gives the frame length, the header split point found by an upstream parser, the number of frame bytes already placed by earlier descriptors, and a 32-bit buffer control word. The engine chooses one of three placements: the whole frame into a single data buffer, the frame into a header buffer and a data buffer, or only the continuation of a long frame into a data buffer. It then issues one or two write commands, waits until every command it issued has completed, and reports the descriptor write-back fields.

The write-back fields are the header length, the split flag, the packet length and end-of-packet. The engine also returns the updated frame offset. The surrounding receive logic passes that offset back in with the next descriptor, and removes the frame from its FIFO only when end-of-packet is reported. A frame larger than one data buffer is therefore carried across as many descriptors as it needs.

The control flow is a six-state machine. From IDLE, a `start` moves it to HDR_CMD when the plan uses the header buffer, to DAT_CMD when only the data buffer is used, or to FAIL when the request is invalid. HDR_CMD goes to DAT_CMD when data is also planned, and otherwise to WAIT_DONE. DAT_CMD always goes to WAIT_DONE. WAIT_DONE goes to REPORT once the completion join is satisfied. REPORT and FAIL each last one cycle and return to IDLE.

Top module: `rx_split_place`

## Requirements
- R1: With `large_pkt_en`=1, the data buffer size is ctrl[7:0]×1024 bytes, the header buffer size is ctrl[15:8] bytes, and the placement type is ctrl[27:25]. With `large_pkt_en`=0, the data buffer size is `glb_buf_bytes` and the header buffer size is 0.
- R2: Type 3'b000 (legacy) and 3'b001 (advanced) select single-buffer placement, and 3'b101 selects header split. Any other type gives a one-cycle `err` pulse and no command.
- R3: Single-buffer placement issues one command with `cmd_sel`=1 (data buffer), offset 0 and length = frame length. It is an error (`err`, no command) if `offset_in`≠0 or the frame length is not smaller than the data buffer size.
- R4: In single-buffer placement, `wb_pkt_len` is the frame length plus 4 when `crc_strip`=0, and the frame length when `crc_strip`=1. In single-buffer placement `wb_hdr_len` and `wb_split` are 0.
- R5: In split mode with `offset_in`=0 and frame length ≤ header buffer size, one command is issued with `cmd_sel`=0 (header buffer), offset 0 and length = frame length. Write-back is header length = frame length, split flag 0 and packet length 0.
- R6: In split mode with `offset_in`=0, a frame larger than the header buffer and a nonzero split point S, a header command (offset 0, length S) is issued, followed by a data command (offset S, length min(frame−S, data buffer size)). Write-back is header length S, split flag 1 and packet length = data length.
- R7: In split mode with `offset_in`=P≠0, one data command is issued with offset P and length min(frame−P, data buffer size). Write-back is header length 0, split flag 0 and packet length = that length. P ≥ frame length is an error.
- R8: Write-back is reported (`wb_valid` for one cycle) exactly one cycle after the completions of all issued commands have been seen. `hdr_done` and `dat_done` may arrive in either order or in the same cycle. A single completion of a two-command placement never reports.
- R9: `off_out` = `offset_in` + bytes placed by this descriptor. `wb_eop` is 1 exactly when `off_out` equals the frame length.
- R10: In split mode with `offset_in`=0, a frame larger than the header buffer and a split point of 0 gives an `err` pulse and issues no command.
- R11: After `start` in IDLE, the first command appears on the next cycle. A header command always precedes the data command by one cycle. `busy` is high from the cycle after `start` until the return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken in IDLE |
| frame_len | input | 16 | Frame length in bytes |
| split_pt | input | 16 | Header split point in bytes, 0 = none found |
| offset_in | input | 16 | Frame bytes already placed by earlier descriptors |
| ctrl | input | 32 | Buffer control word |
| large_pkt_en | input | 1 | Use control-word buffer sizes |
| glb_buf_bytes | input | 18 | Data buffer size when large-packet mode is off |
| crc_strip | input | 1 | CRC already removed from the frame |
| hdr_done | input | 1 | Header write completed |
| dat_done | input | 1 | Data write completed |
| busy | output | 1 | Engine not idle |
| cmd_valid | output | 1 | Write command valid |
| cmd_sel | output | 1 | 0 = header buffer, 1 = data buffer |
| cmd_off | output | 16 | Frame byte offset for the write |
| cmd_len | output | 16 | Write length in bytes |
| wb_valid | output | 1 | Write-back fields valid |
| wb_hdr_len | output | 16 | Reported header length |
| wb_split | output | 1 | Reported split flag |
| wb_pkt_len | output | 16 | Reported packet length |
| wb_eop | output | 1 | End of packet |
| off_out | output | 16 | Updated frame offset |
| err | output | 1 | Invalid request pulse |

## Verification
The assertions check the following on every cycle: the completion counter never passes the number of writes issued, a report follows only a satisfied join, and a header command directly precedes its data command. They also check that a data command never exceeds the data buffer, that end-of-packet coincides with an offset equal to the frame length, and that a rejected request is followed by neither a command nor a report. The scenarios are needed for the actual placement arithmetic: the header-only, split and continuation cases, the 4-byte packet-length adjustment, and the control-word field decoding with large-packet mode on and off. A long frame carried over three descriptors, completion orderings that arrive apart or together, and each error case are also shown only by the scenarios.

// File: rtl/rxsp_pkg.sv
package rxsp_pkg;
    localparam int LEN_W = 16;
    localparam int BUF_W = 18;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR_CMD,
        S_DAT_CMD,
        S_WAIT_DONE,
        S_REPORT,
        S_FAIL
    } fsm_t;

    typedef struct packed {
        logic             bad;
        logic             use_hdr;
        logic             use_dat;
        logic [LEN_W-1:0] hdr_len;
        logic [LEN_W-1:0] dat_off;
        logic [LEN_W-1:0] dat_len;
        logic [BUF_W-1:0] buf_bytes;
        logic [LEN_W-1:0] wb_hdr;
        logic             wb_split;
        logic [LEN_W-1:0] wb_pkt;
        logic [LEN_W-1:0] new_off;
        logic             eop;
    } plan_t;
endpackage

// File: rtl/rxsp_plan.sv
module rxsp_plan
    import rxsp_pkg::*;
#(
    parameter int KB_SHIFT  = 10,
    parameter int CRC_BYTES = 4
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] split_pt,
    input  logic [LEN_W-1:0] offset_in,
    input  logic [31:0]      ctrl,
    input  logic             large_pkt_en,
    input  logic [BUF_W-1:0] glb_buf_bytes,
    input  logic             crc_strip,
    output plan_t            plan_o
);
    localparam logic [2:0] TY_LEGACY = 3'b000;
    localparam logic [2:0] TY_ADV    = 3'b001;
    localparam logic [2:0] TY_SPLIT  = 3'b101;

    logic [2:0]       ptype;
    logic [BUF_W-1:0] dbuf;
    logic [LEN_W-1:0] hbuf;
    logic [LEN_W-1:0] rem_cont, rem_split, take_cont, take_split, placed;

    function automatic logic [LEN_W-1:0] clip(input logic [LEN_W-1:0] want,
                                              input logic [BUF_W-1:0] cap);
        if ({{(BUF_W-LEN_W){1'b0}}, want} < cap) return want;
        return cap[LEN_W-1:0];
    endfunction

    always_comb begin
        ptype      = ctrl[27:25];
        dbuf       = large_pkt_en ? (BUF_W'(ctrl[7:0]) << KB_SHIFT) : glb_buf_bytes;
        hbuf       = large_pkt_en ? LEN_W'(ctrl[15:8]) : '0;
        rem_cont   = frame_len - offset_in;
        rem_split  = (split_pt < frame_len) ? (frame_len - split_pt) : '0;
        take_cont  = clip(rem_cont, dbuf);
        take_split = clip(rem_split, dbuf);
        plan_o     = '0;
        plan_o.buf_bytes = dbuf;
        placed     = '0;
        unique case (ptype)
            TY_LEGACY, TY_ADV: begin
                if (offset_in != '0 || {{(BUF_W-LEN_W){1'b0}}, frame_len} >= dbuf) begin
                    plan_o.bad = 1'b1;
                end else begin
                    plan_o.use_dat = 1'b1;
                    plan_o.dat_len = frame_len;
                    plan_o.wb_pkt  = frame_len + (crc_strip ? LEN_W'(0) : LEN_W'(CRC_BYTES));
                    placed         = frame_len;
                end
            end
            TY_SPLIT: begin
                if (offset_in == '0 && frame_len <= hbuf) begin
                    plan_o.use_hdr = 1'b1;
                    plan_o.hdr_len = frame_len;
                    plan_o.wb_hdr  = frame_len;
                    placed         = frame_len;
                end else if (offset_in != '0) begin
                    if (offset_in >= frame_len) begin
                        plan_o.bad = 1'b1;
                    end else begin
                        plan_o.use_dat = 1'b1;
                        plan_o.dat_off = offset_in;
                        plan_o.dat_len = take_cont;
                        plan_o.wb_pkt  = take_cont;
                        placed         = take_cont;
                    end
                end else if (split_pt != '0) begin
                    plan_o.use_hdr  = 1'b1;
                    plan_o.hdr_len  = split_pt;
                    plan_o.use_dat  = (take_split != '0);
                    plan_o.dat_off  = split_pt;
                    plan_o.dat_len  = take_split;
                    plan_o.wb_hdr   = split_pt;
                    plan_o.wb_split = 1'b1;
                    plan_o.wb_pkt   = take_split;
                    placed          = split_pt + take_split;
                end else begin
                    plan_o.bad = 1'b1;
                end
            end
            default: plan_o.bad = 1'b1;
        endcase
        plan_o.new_off = offset_in + placed;
        plan_o.eop     = !plan_o.bad && (plan_o.new_off == frame_len);
    end
endmodule

// File: rtl/rxsp_join.sv
module rxsp_join (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] need,
    input  logic       hdr_done,
    input  logic       dat_done,
    output logic       joined
);
    logic [1:0] need_q, seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_q <= 2'd0;
            seen_q <= 2'd0;
        end else if (arm) begin
            need_q <= need;
            seen_q <= 2'd0;
        end else begin
            seen_q <= seen_q + {1'b0, hdr_done} + {1'b0, dat_done};
        end
    end

    assign joined = (seen_q == need_q);

    AST_JOIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= need_q); // R8
endmodule

// File: rtl/rx_split_place.sv
module rx_split_place
    import rxsp_pkg::*;
#(
    parameter int KB_SHIFT  = 10,
    parameter int CRC_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] split_pt,
    input  logic [LEN_W-1:0] offset_in,
    input  logic [31:0]      ctrl,
    input  logic             large_pkt_en,
    input  logic [BUF_W-1:0] glb_buf_bytes,
    input  logic             crc_strip,
    input  logic             hdr_done,
    input  logic             dat_done,
    output logic             busy,
    output logic             cmd_valid,
    output logic             cmd_sel,
    output logic [LEN_W-1:0] cmd_off,
    output logic [LEN_W-1:0] cmd_len,
    output logic             wb_valid,
    output logic [LEN_W-1:0] wb_hdr_len,
    output logic             wb_split,
    output logic [LEN_W-1:0] wb_pkt_len,
    output logic             wb_eop,
    output logic [LEN_W-1:0] off_out,
    output logic             err
);
    plan_t            pl, pl_q;
    fsm_t             st, st_nx;
    logic             joined, take;
    logic [LEN_W-1:0] frame_q;

    assign take = start && (st == S_IDLE);

    rxsp_plan #(.KB_SHIFT(KB_SHIFT), .CRC_BYTES(CRC_BYTES)) u_plan (
        .frame_len(frame_len), .split_pt(split_pt), .offset_in(offset_in),
        .ctrl(ctrl), .large_pkt_en(large_pkt_en), .glb_buf_bytes(glb_buf_bytes),
        .crc_strip(crc_strip), .plan_o(pl)
    );

    rxsp_join u_join (
        .clk(clk), .rst_n(rst_n), .arm(take),
        .need({1'b0, pl.use_hdr} + {1'b0, pl.use_dat}),
        .hdr_done(hdr_done), .dat_done(dat_done), .joined(joined)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            pl_q    <= '0;
            frame_q <= '0;
        end else begin
            st <= st_nx;
            if (take) begin
                pl_q    <= pl;
                frame_q <= frame_len;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (pl.bad)          st_nx = S_FAIL;
                    else if (pl.use_hdr) st_nx = S_HDR_CMD;
                    else                 st_nx = S_DAT_CMD;
                end
            end
            S_HDR_CMD:   st_nx = pl_q.use_dat ? S_DAT_CMD : S_WAIT_DONE;
            S_DAT_CMD:   st_nx = S_WAIT_DONE;
            S_WAIT_DONE: if (joined) st_nx = S_REPORT;
            S_REPORT:    st_nx = S_IDLE;
            S_FAIL:      st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy       = (st != S_IDLE);
        cmd_valid  = (st == S_HDR_CMD) || (st == S_DAT_CMD);
        cmd_sel    = (st == S_DAT_CMD);
        cmd_off    = (st == S_DAT_CMD) ? pl_q.dat_off : '0;
        cmd_len    = (st == S_DAT_CMD) ? pl_q.dat_len : pl_q.hdr_len;
        wb_valid   = (st == S_REPORT);
        wb_hdr_len = pl_q.wb_hdr;
        wb_split   = pl_q.wb_split;
        wb_pkt_len = pl_q.wb_pkt;
        wb_eop     = (st == S_REPORT) && pl_q.eop;
        off_out    = pl_q.new_off;
        err        = (st == S_FAIL);
    end

    AST_REPORT_AFTER_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(joined)); // R8
    AST_HDR_BEFORE_DAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_sel && pl_q.use_hdr) |-> $past(cmd_valid && !cmd_sel)); // R11
    AST_DAT_WITHIN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_sel) |-> ({2'b00, cmd_len} <= pl_q.buf_bytes)); // R7
    AST_EOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_eop) |-> (off_out == frame_q)); // R9
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!cmd_valid && !wb_valid)); // R10
    AST_SPLIT_HAS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_split) |-> (wb_hdr_len != '0)); // R6
endmodule

// File: tb/rx_split_place_test.sv
module rx_split_place_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] frame_len = '0, split_pt = '0, offset_in = '0;
    logic [31:0] ctrl = '0;
    logic        large_pkt_en = 1'b0;
    logic [17:0] glb_buf_bytes = '0;
    logic        crc_strip = 1'b0;
    logic        hdr_done = 1'b0, dat_done = 1'b0;
    logic        busy, cmd_valid, cmd_sel, wb_valid, wb_split, wb_eop, err;
    logic [15:0] cmd_off, cmd_len, wb_hdr_len, wb_pkt_len, off_out;

    int checks = 0;
    int errors = 0;
    int cmd_seen = 0;
    int res_seen = 0;
    bit finished = 1'b0;

    logic [32:0] cmd_q[$];
    string       cmd_tag[$];
    logic [50:0] res_q[$];
    string       res_tag[$];

    always #2.5 clk = ~clk;

    rx_split_place uut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .split_pt(split_pt), .offset_in(offset_in), .ctrl(ctrl),
        .large_pkt_en(large_pkt_en), .glb_buf_bytes(glb_buf_bytes),
        .crc_strip(crc_strip), .hdr_done(hdr_done), .dat_done(dat_done),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_off(cmd_off),
        .cmd_len(cmd_len), .wb_valid(wb_valid), .wb_hdr_len(wb_hdr_len),
        .wb_split(wb_split), .wb_pkt_len(wb_pkt_len), .wb_eop(wb_eop),
        .off_out(off_out), .err(err)
    );

    function automatic logic [31:0] mk(input logic [2:0] ty, input logic [7:0] hsz,
                                       input logic [7:0] kb);
        return {4'b0, ty, 9'b0, hsz, kb};
    endfunction

    // monitor: pops expectations as the design produces them
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            logic [32:0] e;
            string t;
            checks++;
            if (cmd_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected command act=%h exp=none", "R11", {cmd_sel, cmd_off, cmd_len});
            end else begin
                e = cmd_q.pop_front();
                t = cmd_tag.pop_front();
                if (e !== {cmd_sel, cmd_off, cmd_len}) begin
                    errors++;
                    $display("FAIL %s command act sel=%0d off=%0d len=%0d exp sel=%0d off=%0d len=%0d",
                             t, cmd_sel, cmd_off, cmd_len, e[32], e[31:16], e[15:0]);
                end
            end
            cmd_seen++;
        end
        if (rst_n && (wb_valid || err)) begin
            logic [50:0] e, a;
            string t;
            a = {err, wb_hdr_len, wb_split, wb_pkt_len, wb_eop, off_out};
            checks++;
            if (res_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected result act=%h exp=none", "R8", a);
            end else begin
                e = res_q.pop_front();
                t = res_tag.pop_front();
                if (e[50]) begin
                    if (!err) begin
                        errors++;
                        $display("FAIL %s act err=0 exp err=1", t);
                    end
                end else if (e !== a) begin
                    errors++;
                    $display("FAIL %s result act err=%0d hdr=%0d sp=%0d pkt=%0d eop=%0d off=%0d exp err=%0d hdr=%0d sp=%0d pkt=%0d eop=%0d off=%0d",
                             t, a[50], a[49:34], a[33], a[32:17], a[16], a[15:0],
                             e[50], e[49:34], e[33], e[32:17], e[16], e[15:0]);
                end
            end
            res_seen++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // mode 0: header completion first, 1: data first, 2: both together
    task automatic run(input string tag, input logic [31:0] c, input bit lg,
                       input logic [17:0] gb, input bit cs, input logic [15:0] fl,
                       input logic [15:0] sp, input logic [15:0] of, input int mode,
                       input bit eh, input logic [15:0] hl,
                       input bit ed, input logic [15:0] doff, input logic [15:0] dl,
                       input bit ee, input logic [15:0] rh, input bit rs,
                       input logic [15:0] rp, input bit rx, input logic [15:0] ro);
        int want_cmd, want_res, guard;
        if (eh) begin cmd_q.push_back({1'b0, 16'd0, hl}); cmd_tag.push_back(tag); end
        if (ed) begin cmd_q.push_back({1'b1, doff, dl});   cmd_tag.push_back(tag); end
        res_q.push_back({ee, rh, rs, rp, rx, ro});
        res_tag.push_back(tag);
        want_cmd = cmd_seen + int'(eh) + int'(ed);
        want_res = res_seen + 1;
        @(negedge clk);
        ctrl = c; large_pkt_en = lg; glb_buf_bytes = gb; crc_strip = cs;
        frame_len = fl; split_pt = sp; offset_in = of; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy === 1'b1, "R11 busy after start", int'(busy), 1);
        guard = 0;
        while (cmd_seen < want_cmd && guard < 20) begin
            @(negedge clk); #1; guard++;
        end
        if (eh && ed && mode != 2) begin
            if (mode == 0) hdr_done = 1'b1; else dat_done = 1'b1;
            @(negedge clk); #1;
            hdr_done = 1'b0; dat_done = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1;
                chk(wb_valid === 1'b0, "R8 no report after one completion", int'(wb_valid), 0);
            end
            if (mode == 0) dat_done = 1'b1; else hdr_done = 1'b1;
        end else begin
            hdr_done = eh; dat_done = ed;
        end
        if (eh || ed) begin
            @(negedge clk); #1;
            hdr_done = 1'b0; dat_done = 1'b0;
        end
        guard = 0;
        while (res_seen < want_res && guard < 20) begin
            @(negedge clk); #1; guard++;
        end
        chk(res_seen == want_res, {tag, " result seen"}, res_seen, want_res);
        @(negedge clk); #1;
        chk(busy === 1'b0, "R11 idle after result", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && cmd_valid === 1'b0 && wb_valid === 1'b0 && err === 1'b0,
            "R11 reset state", int'({busy, cmd_valid, wb_valid, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 R4: legacy single buffer, CRC kept
        run("R4 legacy single crc", mk(3'b000, 8'd0, 8'd2), 1, 0, 0, 16'd1000, 16'd0, 16'd0, 0,
            0, 0, 1, 0, 1000, 0, 0, 0, 1004, 1, 1000);
        // R1: large-packet off uses global size
        run("R1 global buffer size", mk(3'b001, 8'd0, 8'd0), 0, 18'd1536, 1, 16'd1500, 16'd0, 16'd0, 0,
            0, 0, 1, 0, 1500, 0, 0, 0, 1500, 1, 1500);
        // R3: frame not smaller than buffer
        run("R3 single too large", mk(3'b001, 8'd0, 8'd2), 1, 0, 1, 16'd2048, 16'd0, 16'd0, 0,
            0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R3: nonzero offset in single mode
        run("R3 single offset", mk(3'b000, 8'd0, 8'd4), 1, 0, 1, 16'd500, 16'd0, 16'd10, 0,
            0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R5: whole frame into header
        run("R5 header only", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd100, 16'd14, 16'd0, 0,
            1, 100, 0, 0, 0, 0, 100, 0, 0, 1, 100);
        // R5 boundary: frame equals header size
        run("R5 header exact", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd128, 16'd14, 16'd0, 0,
            1, 128, 0, 0, 0, 0, 128, 0, 0, 1, 128);
        // R6 R8: split, data completes first
        run("R6 split fits", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd1000, 16'd54, 16'd0, 1,
            1, 54, 1, 54, 946, 0, 54, 1, 946, 1, 1000);
        // R6 R8: split of long frame, completions together
        run("R6 split long", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd5000, 16'd42, 16'd0, 2,
            1, 42, 1, 42, 2048, 0, 42, 1, 2048, 0, 2090);
        // R7 R9: continuation, not last
        run("R7 continue mid", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd5000, 16'd42, 16'd2090, 0,
            0, 0, 1, 2090, 2048, 0, 0, 0, 2048, 0, 4138);
        // R7 R9: continuation, last piece
        run("R9 continue last", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd5000, 16'd42, 16'd4138, 0,
            0, 0, 1, 4138, 862, 0, 0, 0, 862, 1, 5000);
        // R8: header first, apart
        run("R8 header first", mk(3'b101, 8'd64, 8'd1), 1, 0, 0, 16'd300, 16'd20, 16'd0, 0,
            1, 20, 1, 20, 280, 0, 20, 1, 280, 1, 300);
        // R10: no split point
        run("R10 no split point", mk(3'b101, 8'd128, 8'd2), 1, 0, 1, 16'd1000, 16'd0, 16'd0, 0,
            0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R2: reserved type
        run("R2 bad type", mk(3'b011, 8'd128, 8'd2), 1, 0, 1, 16'd100, 16'd14, 16'd0, 0,
            0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R1: large-packet off forces header size 0 in split mode
        run("R1 split header zero", mk(3'b101, 8'd128, 8'd0), 0, 18'd1024, 1, 16'd60, 16'd14, 16'd0, 2,
            1, 14, 1, 14, 46, 0, 14, 1, 46, 1, 60);
        chk(cmd_q.size() == 0, "R11 all commands seen", cmd_q.size(), 0);
        chk(res_q.size() == 0, "R8 all results seen", res_q.size(), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule